// File: doc/BRIEF.md
# Paged NIC Command and Interrupt Controller

This block is the host-side register front end of a simple Ethernet network controller. The host reaches it through a 4-bit register offset, a write strobe and a data byte. Reads are combinational. A 2-bit page field held in the command byte decides which register an offset reaches. The mapping also differs between reads and writes. On page 0 several configuration registers can only be written, and page 2 lets the host read them back. The command byte appears at offset 0 on every page.

The command byte carries four things: the stop and start handshake that moves the controller between its stopped and running states, a transmit request that clears itself, the remote DMA command field with its abort code, and the page select. A stop request does not take effect while a transfer is still in progress. Leaving the stopped state takes a start command with the stop bit clear.

Transmit, receive and DMA engines report events as single-cycle pulses. The block latches these pulses into an interrupt status byte whose low seven bits are cleared by writing one. A mask byte gates the status bits, and the result drives one registered interrupt line. Status bit 7 is read-only and tracks the reset or overwrite condition.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: After power-on reset the controller is stopped with page 0 selected. The command byte reads 0x21, made up of stop=1, start=0, transmit request=0, DMA field=100 and page=00. The interrupt status reads 0x80, the interrupt output is 0, and every configuration register is 0.
- R2: A write to offset 0 on any page reaches the command byte, and a read of offset 0 on any page returns it. Bits 7:6 select the page. Bit 0 reads 1 while the controller is stopped or a stop is pending, and bit 1 reads 1 while it is running.
- R3: Page 0 writes go to these registers: offset 1 to page start, 2 to page stop, 4 to transmit page start, 0x0C to receive config, 0x0D to transmit config, 0x0E to data config and 0x0F to the interrupt mask. Page 0 reads return other things: offset 4 returns the transmit status input, offset 7 the interrupt status and offset 0x0F the tally input. All other page 0 offsets except 0 read 0.
- R4: Page 2 reads return the seven configuration registers at the same offsets used to write them on page 0. Every other page 2 offset except 0 reads 0. Page 2 writes to offsets other than 0 are ignored. On pages 1 and 3, writes to offsets other than 0 are ignored and reads of those offsets return 0.
- R5: The DMA field (command bits 5:3) takes the written value 001 (remote read), 010 (remote write) or 011 (send packet). Any written value with bit 5 set is stored as 100 (abort). A written 000 leaves the field unchanged.
- R6: Writing command bit 2 while the controller is not stopped sets the transmit request. The request clears on a transmit-complete pulse or a transmit-error pulse. Writing bit 2 while the controller is stopped has no effect.
- R7: A command write with bit 0 set stops the controller on the next edge at which the transfer-busy input is low. While that input is high, the controller stays running.
- R8: A command write with bit 0 clear and bit 1 set leaves the stopped state and clears status bit 7. A write with both bits set leaves the controller stopped.
- R9: Status bits 0 to 6 are set by pulses on, in order, receive-ok, transmit-ok, receive-error, transmit-error, overwrite, counter-overflow and DMA-done. Writing a 1 to a bit at page 0 offset 7 clears that bit. An event pulse in the same cycle wins over the clear.
- R10: Status bit 7 cannot be written. It is set on entering the stopped state and on an overwrite pulse. While the controller is running it is cleared by a start command or a ring-free pulse.
- R11: The interrupt output is a register that takes the OR of the status bits 0 to 6 ANDed with mask bits 0 to 6. It therefore rises one cycle after the status bit does. Mask bit 7 is reserved and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| xferBusy | input | 1 | A transfer is in progress; delays stop |
| evRxOk | input | 1 | Pulse: packet received |
| evTxOk | input | 1 | Pulse: packet transmitted |
| evRxErr | input | 1 | Pulse: receive error |
| evTxErr | input | 1 | Pulse: transmit error or abort |
| evOverwrite | input | 1 | Pulse: receive ring overwrite |
| evCntOvf | input | 1 | Pulse: tally counter overflow |
| evDmaDone | input | 1 | Pulse: remote DMA complete |
| evRingFree | input | 1 | Pulse: a packet was removed from the ring |
| txStatIn | input | 8 | Transmit status, read at page 0 offset 4 |
| tallyIn | input | 8 | Tally counter, read at page 0 offset 0x0F |
| irq | output | 1 | Registered interrupt request |
| txRequest | output | 1 | Transmit request bit |
| dmaCmd | output | 3 | Remote DMA command field |
| stopped | output | 1 | Controller is in the stopped state |
| pageStart | output | 8 | Receive ring start page |
| pageStop | output | 8 | Receive ring stop page |
| txPageStart | output | 8 | Transmit buffer start page |
| rxCfg | output | 8 | Receive configuration |
| txCfg | output | 8 | Transmit configuration |
| dataCfg | output | 8 | Data configuration |

## Verification
The decode is swept over all 64 page and offset pairs for reads, and the bench computes each expected byte from a register model kept in the bench. The sweep is repeated after writes with distinct data on pages 0 and 2, so a write leaking into the wrong page or offset shows up as a changed read. Each of the seven event sources is pulsed alone under two mask patterns, which separates a wrong bit position from a missing mask gate and checks the one-cycle interrupt latency. Further sequences cover a clear that collides with an event, each DMA code including 000 and the abort codes, the transmit request under both terminating pulses and while stopped, a stop held off by the busy input, and the two ways status bit 7 is cleared.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 4;
  localparam int PAGE_W = 2;
  localparam int EVT_N  = 7;
  localparam int DMA_W  = 3;
  localparam int CFG_N  = 7;

  // Register offsets whose position matters to the host decode
  localparam logic [OFF_W-1:0] OFF_CMD    = 4'h0;
  localparam logic [OFF_W-1:0] OFF_TXSTAT = 4'h4;
  localparam logic [OFF_W-1:0] OFF_ISR    = 4'h7;
  localparam logic [OFF_W-1:0] OFF_TALLY  = 4'hF;

  // Configuration slots: write on page 0, read on page 2
  localparam logic [OFF_W-1:0] CFG_OFF [CFG_N] =
    '{4'h1, 4'h2, 4'h4, 4'hC, 4'hD, 4'hE, 4'hF};
  localparam int CFG_PSTART = 0;
  localparam int CFG_PSTOP  = 1;
  localparam int CFG_TPSR   = 2;
  localparam int CFG_RXCFG  = 3;
  localparam int CFG_TXCFG  = 4;
  localparam int CFG_DCFG   = 5;
  localparam int CFG_MASK   = 6;

  localparam logic [DMA_W-1:0] DMA_ABORT = 3'b100;

  typedef struct packed {
    logic              enterStop;
    logic              startCmd;
    logic              running;
    logic [PAGE_W-1:0] page;
  } ctlStrobes_t;
endpackage

// File: rtl/nic_cmd_ctl.sv
module nic_cmd_ctl
  import nic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              xferBusy,
  input  logic              txEnd,
  output ctlStrobes_t       strb,
  output logic              txReq,
  output logic [DMA_W-1:0]  dmaCmd,
  output logic              stopped,
  output logic [DATA_W-1:0] crRead
);
  logic              crWr, stopWr, startWr, enterStop, txSetNow;
  logic              stopReq;
  logic [PAGE_W-1:0] pageQ;

  assign crWr      = wrEn && (addr == OFF_CMD);
  assign stopWr    = crWr && wrData[0];
  assign startWr   = crWr && !wrData[0] && wrData[1];
  assign enterStop = !stopped && (stopWr || stopReq) && !xferBusy;
  assign txSetNow  = crWr && wrData[2] && !stopped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopped <= 1'b1;
      stopReq <= 1'b0;
    end else if (startWr) begin
      stopped <= 1'b0;
      stopReq <= 1'b0;
    end else if (enterStop) begin
      stopped <= 1'b1;
      stopReq <= 1'b0;
    end else if (stopWr && !stopped) begin
      stopReq <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         txReq <= 1'b0;
    else if (txSetNow) txReq <= 1'b1;
    else if (txEnd)    txReq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaCmd <= DMA_ABORT;
      pageQ  <= '0;
    end else if (crWr) begin
      pageQ <= wrData[7:6];
      if (wrData[5])                dmaCmd <= DMA_ABORT;
      else if (wrData[4:3] != 2'b0) dmaCmd <= wrData[5:3];
    end
  end

  assign strb.enterStop = enterStop;
  assign strb.startCmd  = startWr;
  assign strb.running   = !stopped;
  assign strb.page      = pageQ;

  assign crRead = {pageQ, dmaCmd, txReq, !stopped && !stopReq, stopped || stopReq};

  // R6
  txp_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnd && !txSetNow) |=> !txReq);
  // R6
  txp_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && !txReq) |=> !txReq);
  // R7
  stop_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopped && xferBusy) |=> !stopped);
  // R8
  start_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> !stopped);
  // R5
  dma_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaCmd != 3'b000);
endmodule

// File: rtl/nic_reg_dp.sv
module nic_reg_dp
  import nic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  addr,
  input  logic [DATA_W-1:0] wrData,
  input  ctlStrobes_t       strb,
  input  logic [EVT_N-1:0]  evt,
  input  logic              ringFree,
  input  logic [DATA_W-1:0] txStatIn,
  input  logic [DATA_W-1:0] tallyIn,
  input  logic [DATA_W-1:0] crRead,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [DATA_W-1:0] cfgOut [CFG_N]
);
  logic             p0Wr;
  logic [EVT_N-1:0] isrLo, clrMask;
  logic             rstFlag;
  logic [EVT_N-1:0] maskBits;

  assign p0Wr = wrEn && (strb.page == 2'd0);

  generate
    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
      localparam logic [DATA_W-1:0] KEEP = (g == CFG_MASK) ? 8'h7F : 8'hFF;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                           q <= '0;
        else if (p0Wr && addr == CFG_OFF[g]) q <= wrData & KEEP;
      end
      assign cfgOut[g] = q;
    end
  endgenerate

  assign maskBits = cfgOut[CFG_MASK][EVT_N-1:0];
  assign clrMask  = (p0Wr && addr == OFF_ISR) ? wrData[EVT_N-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) isrLo <= '0;
    else       isrLo <= (isrLo & ~clrMask) | evt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 rstFlag <= 1'b1;
    else if (strb.enterStop || evt[4])         rstFlag <= 1'b1;
    else if (strb.startCmd)                    rstFlag <= 1'b0;
    else if (ringFree && strb.running)         rstFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(isrLo & maskBits);
  end

  always_comb begin
    rdData = '0;
    if (addr == OFF_CMD) begin
      rdData = crRead;
    end else begin
      unique case (strb.page)
        2'd0: begin
          if (addr == OFF_TXSTAT)     rdData = txStatIn;
          else if (addr == OFF_ISR)   rdData = {rstFlag, isrLo};
          else if (addr == OFF_TALLY) rdData = tallyIn;
        end
        2'd2: begin
          for (int i = 0; i < CFG_N; i++)
            if (addr == CFG_OFF[i]) rdData = cfgOut[i];
        end
        default: rdData = '0;
      endcase
    end
  end

  // R9
  evt_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt != '0) |=> ((isrLo & $past(evt)) == $past(evt)));
  // R10
  rst_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt[4] |=> rstFlag);
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((isrLo & maskBits) == '0) |=> !irq);
  // R11
  mask_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOut[CFG_MASK][7]);
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              xferBusy,
  input  logic              evRxOk,
  input  logic              evTxOk,
  input  logic              evRxErr,
  input  logic              evTxErr,
  input  logic              evOverwrite,
  input  logic              evCntOvf,
  input  logic              evDmaDone,
  input  logic              evRingFree,
  input  logic [DATA_W-1:0] txStatIn,
  input  logic [DATA_W-1:0] tallyIn,
  output logic              irq,
  output logic              txRequest,
  output logic [DMA_W-1:0]  dmaCmd,
  output logic              stopped,
  output logic [DATA_W-1:0] pageStart,
  output logic [DATA_W-1:0] pageStop,
  output logic [DATA_W-1:0] txPageStart,
  output logic [DATA_W-1:0] rxCfg,
  output logic [DATA_W-1:0] txCfg,
  output logic [DATA_W-1:0] dataCfg
);
  ctlStrobes_t       strb;
  logic [DATA_W-1:0] crRead;
  logic [DATA_W-1:0] cfgOut [CFG_N];
  logic [EVT_N-1:0]  evt;

  assign evt = {evDmaDone, evCntOvf, evOverwrite, evTxErr, evRxErr, evTxOk, evRxOk};

  nic_cmd_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .xferBusy(xferBusy), .txEnd(evTxOk | evTxErr), .strb(strb),
    .txReq(txRequest), .dmaCmd(dmaCmd), .stopped(stopped), .crRead(crRead)
  );

  nic_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .evt(evt), .ringFree(evRingFree), .txStatIn(txStatIn),
    .tallyIn(tallyIn), .crRead(crRead), .rdData(rdData), .irq(irq),
    .cfgOut(cfgOut)
  );

  assign pageStart   = cfgOut[CFG_PSTART];
  assign pageStop    = cfgOut[CFG_PSTOP];
  assign txPageStart = cfgOut[CFG_TPSR];
  assign rxCfg       = cfgOut[CFG_RXCFG];
  assign txCfg       = cfgOut[CFG_TXCFG];
  assign dataCfg     = cfgOut[CFG_DCFG];
endmodule

// File: tb/nic_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module nic_cmd_ctrl_bench;
  logic       clk = 0, rstN = 0, wrEn = 0, xferBusy = 0, ringFree = 0;
  logic [3:0] addr = 0;
  logic [7:0] wrData = 0, rdData, txStatIn = 8'hA5, tallyIn = 8'h3C;
  logic [6:0] evB = 0;
  logic       irq, txRequest, stopped;
  logic [2:0] dmaCmd;
  logic [7:0] pageStart, pageStop, txPageStart, rxCfg, txCfg, dataCfg;
  int nChk = 0, nBad = 0;
  bit done = 0;

  // bench model of the configuration registers, indexed by offset
  logic [7:0] mCfg [16];
  logic [7:0] mCr;
  logic [7:0] mIsr;

  always #2 clk = ~clk;

  nic_cmd_ctrl u_nic_cmd_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .xferBusy(xferBusy),
    .evRxOk(evB[0]), .evTxOk(evB[1]), .evRxErr(evB[2]), .evTxErr(evB[3]),
    .evOverwrite(evB[4]), .evCntOvf(evB[5]), .evDmaDone(evB[6]),
    .evRingFree(ringFree), .txStatIn(txStatIn), .tallyIn(tallyIn),
    .irq(irq), .txRequest(txRequest), .dmaCmd(dmaCmd), .stopped(stopped),
    .pageStart(pageStart), .pageStop(pageStop), .txPageStart(txPageStart),
    .rxCfg(rxCfg), .txCfg(txCfg), .dataCfg(dataCfg)
  );

  task automatic chk(input string req, input [7:0] act, input [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input [3:0] a, input [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk); wrEn = 0;
  endtask

  task automatic pulse(input [6:0] e, input rf);
    @(negedge clk); evB = e; ringFree = rf;
    @(posedge clk); @(negedge clk); evB = 0; ringFree = 0;
  endtask

  task automatic rd(input [3:0] a, output [7:0] d);
    addr = a; #0.5; d = rdData;
  endtask

  function automatic bit isCfgOff(input [3:0] o);
    return o == 1 || o == 2 || o == 4 || o == 12 || o == 13 || o == 14 || o == 15;
  endfunction

  function automatic [7:0] expRd(input [1:0] pg, input [3:0] o);
    if (o == 0) return mCr;
    if (pg == 0) begin
      if (o == 4) return txStatIn;
      if (o == 7) return mIsr;
      if (o == 15) return tallyIn;
      return 8'h00;
    end
    if (pg == 2 && isCfgOff(o)) return mCfg[o];
    return 8'h00;
  endfunction

  task automatic selPage(input [1:0] pg);
    wr(0, {pg, 3'b100, 3'b010});
    mCr = {pg, 3'b100, 3'b010};
  endtask

  task automatic sweep(input string tag);
    logic [7:0] d;
    for (int pg = 0; pg < 4; pg++) begin
      selPage(pg[1:0]);
      for (int o = 0; o < 16; o++) begin
        rd(o[3:0], d);
        chk($sformatf("%s p%0d o%0h", tag, pg, o), d, expRd(pg[1:0], o[3:0]));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] imrPat;
    for (int i = 0; i < 16; i++) mCfg[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, d); chk("R1 command byte", d, 8'h21);
    rd(7, d); chk("R1 status", d, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 stopped", {7'b0, stopped}, 8'h01);
    chk("R1 dma", {5'b0, dmaCmd}, 8'h04);
    chk("R1 cfg", pageStart | pageStop | txPageStart | rxCfg | txCfg | dataCfg, 8'h00);

    // R6 transmit request ignored while stopped
    wr(0, 8'h25);
    chk("R6 txp while stopped", {7'b0, txRequest}, 8'h00);

    // R8 start with stop set stays stopped, then a clean start
    wr(0, 8'h23);
    chk("R8 start+stop stays stopped", {7'b0, stopped}, 8'h01);
    wr(0, 8'h22);
    chk("R8 running", {7'b0, stopped}, 8'h00);
    rd(7, d); chk("R8 status bit7 cleared", d, 8'h00);
    mCr = 8'h22; mIsr = 8'h00;

    // R2 R4 read sweep over every page and offset, all config zero
    sweep("R2 R4 zero sweep");

    // R3 page 0 writes with distinct data
    selPage(0);
    for (int o = 1; o < 16; o++) begin
      if (isCfgOff(o[3:0])) begin
        wr(o[3:0], 8'h80 | (o[7:0] * 8'd9));
        mCfg[o] = (o == 15) ? ((8'h80 | (o[7:0] * 8'd9)) & 8'h7F) : (8'h80 | (o[7:0] * 8'd9));
      end
    end
    chk("R3 pageStart out", pageStart, mCfg[1]);
    chk("R3 pageStop out", pageStop, mCfg[2]);
    chk("R3 txPageStart out", txPageStart, mCfg[4]);
    chk("R3 rxCfg out", rxCfg, mCfg[12]);
    chk("R3 txCfg out", txCfg, mCfg[13]);
    chk("R3 dataCfg out", dataCfg, mCfg[14]);

    // R4 writes on pages 1, 2, 3 to non-zero offsets are ignored
    for (int pg = 1; pg < 4; pg++) begin
      selPage(pg[1:0]);
      for (int o = 1; o < 16; o++) wr(o[3:0], 8'h5A);
    end
    sweep("R3 R4 R11 loaded sweep");

    // R5 DMA field codes
    selPage(0);
    wr(0, 8'h0A); chk("R5 remote read", {5'b0, dmaCmd}, 8'h01);
    wr(0, 8'h02); chk("R5 000 ignored", {5'b0, dmaCmd}, 8'h01);
    wr(0, 8'h12); chk("R5 remote write", {5'b0, dmaCmd}, 8'h02);
    wr(0, 8'h1A); chk("R5 send packet", {5'b0, dmaCmd}, 8'h03);
    wr(0, 8'h3A); chk("R5 abort 111", {5'b0, dmaCmd}, 8'h04);
    wr(0, 8'h1A); wr(0, 8'h2A); chk("R5 abort 101", {5'b0, dmaCmd}, 8'h04);
    rd(0, d); chk("R2 readback", d, 8'h22);

    // R6 transmit request clears on either end pulse
    wr(0, 8'h26);
    chk("R6 txp set", {7'b0, txRequest}, 8'h01);
    rd(0, d); chk("R2 txp bit", d, 8'h26);
    wr(0, 8'h22);
    chk("R6 writing 0 keeps txp", {7'b0, txRequest}, 8'h01);
    pulse(7'h02, 0);
    chk("R6 cleared by tx ok", {7'b0, txRequest}, 8'h00);
    wr(0, 8'h26);
    pulse(7'h08, 0);
    chk("R6 cleared by tx err", {7'b0, txRequest}, 8'h00);
    wr(7, 8'h7F);

    // R9 R11 each event under two mask patterns
    for (int m = 0; m < 2; m++) begin
      imrPat = (m == 0) ? 8'h7F : 8'h55;
      wr(15, imrPat);
      for (int i = 0; i < 7; i++) begin
        pulse(7'(1 << i), 0);
        rd(7, d);
        chk($sformatf("R9 event %0d", i), d, (i == 4) ? (8'h80 | 8'(1 << i)) : 8'(1 << i));
        chk($sformatf("R11 irq latency %0d", i), {7'b0, irq}, 8'h00);
        @(posedge clk); @(negedge clk);
        chk($sformatf("R11 irq %0d mask %02h", i, imrPat), {7'b0, irq}, {7'b0, imrPat[i]});
        wr(7, 8'(1 << i));
        rd(7, d);
        chk($sformatf("R9 clear %0d", i), d, (i == 4) ? 8'h80 : 8'h00);
        if (i == 4) begin
          pulse(7'h00, 1);
          rd(7, d); chk("R10 ring free clears bit7", d, 8'h00);
        end
      end
    end

    // R9 event wins over a same-cycle clear
    @(negedge clk); wrEn = 1; addr = 7; wrData = 8'h7F; evB = 7'h01;
    @(posedge clk); @(negedge clk); wrEn = 0; evB = 0;
    rd(7, d); chk("R9 event beats clear", d, 8'h01);
    // R10 bit 7 cannot be written
    wr(7, 8'hFF);
    rd(7, d); chk("R10 bit7 write ignored", d, 8'h00);

    // R7 stop waits for busy low
    xferBusy = 1;
    wr(0, 8'h21);
    chk("R7 running while busy", {7'b0, stopped}, 8'h00);
    rd(0, d); chk("R2 stop pending reads stop", d, 8'h21);
    rd(7, d); chk("R7 bit7 not yet", d, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 still running", {7'b0, stopped}, 8'h00);
    xferBusy = 0;
    @(posedge clk); @(negedge clk);
    chk("R7 stopped after busy", {7'b0, stopped}, 8'h01);
    rd(7, d); chk("R10 bit7 on stop", d, 8'h80);
    pulse(7'h00, 1);
    rd(7, d); chk("R10 ring free ignored while stopped", d, 8'h80);
    wr(0, 8'h22);
    rd(7, d); chk("R8 start clears bit7", d, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule